// File: doc/BRIEF.md
# Result Compare Monitor with Match Count

This block watches the stream of conversion results as they are written into the result registers. It holds two independent compare units. Each unit is tied to one channel code, tests every result written for that channel against a 12-bit threshold, and counts consecutive qualifying results. When the run of matches reaches the programmed count plus one, the unit sets a sticky flag. The flag can raise a shared interrupt line.

A result write shows up as a one-cycle strobe with a channel code and 12-bit data. A global format input selects the kind of comparison. When it is 0, data and threshold are unsigned. When it is 1, both are 12-bit two's complement. Software programs each unit through plain configuration inputs and clears a flag with a one-cycle write-1 pulse.

Each unit runs a two-state machine. ST_IDLE means no qualifying result is pending and the counter is zero. ST_COUNT means a run of matches is under way. The transitions are:
- T_START (ST_IDLE to ST_COUNT): a match that does not yet complete the run.
- T_HIT_IDLE (ST_IDLE stays in ST_IDLE): the programmed count is 0 and one match completes the run.
- T_HIT (ST_COUNT to ST_IDLE): a match completes the run.
- T_MISS (ST_COUNT to ST_IDLE): a non-matching result on the selected channel.
- T_OFF (ST_COUNT to ST_IDLE): the unit is disabled.

Top module: `cmp_monitor`

## Requirements
- R1: A unit evaluates only results whose channel code equals its 4-bit channel select. Codes 0 to 11 are external channels, 12 is the band-gap result and 13 is the temperature result. Results for any other code leave the unit's match count unchanged.
- R2: With condition bit 0, a result counts as a match when it is strictly below the threshold.
- R3: With condition bit 1, a result counts as a match when it is greater than or equal to the threshold.
- R4: A unit's flag rises in the cycle after the write strobe that brings its run of consecutive matches to the 4-bit match count plus one. It does not rise before that.
- R5: A non-matching result on the selected channel restarts the run from zero.
- R6: When the flag sets, the run restarts from zero, so a full new run is needed to complete again.
- R7: With the format input at 0 the comparison is unsigned. With it at 1, both data and threshold are compared as 12-bit two's complement, so 0xFFF is -1.
- R8: A flag stays set until a clear pulse for that unit arrives. The flag is then 0 from the next cycle. If a completion and a clear happen in the same cycle, the flag stays set.
- R9: The interrupt output is high whenever some unit has its flag set and its interrupt enable at 1. Otherwise it is low.
- R10: While a unit is disabled it ignores results and its run restarts from zero. Its flag keeps its value.
- R11: The two units are independent. A result can advance or complete either unit according to that unit's own settings.
- R12: After reset both flags and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle result write strobe |
| wr_chan | input | 4 | Channel code of the written result |
| wr_data | input | 12 | Written result |
| fmt_signed | input | 1 | 1 means two's complement compare |
| cfg_en | input | 2 | Per-unit enable |
| cfg_irq_en | input | 2 | Per-unit interrupt enable |
| cfg_cond | input | 2 | Per-unit condition (0 is below, 1 is at or above) |
| cfg_chan | input | 8 | Channel select, unit u in bits [4u+3:4u] |
| cfg_mcnt | input | 8 | Match count, unit u in bits [4u+3:4u] |
| cfg_thresh | input | 24 | Threshold, unit u in bits [12u+11:12u] |
| flag_clr | input | 2 | Per-unit write-1 clear pulse |
| flag | output | 2 | Sticky compare flags |
| irq | output | 1 | Compare interrupt |

## Verification
The hardest situation to reach is a half-finished run that some event should silently erase or leave untouched. Examples are a result on a foreign channel, a mismatch, or a short disable pulse. The count itself never appears at the ports. The directed tasks therefore first build a partial run of known length and then inject the event. They then send exactly the number of further matches that would complete the run under the required behaviour, and check the flag one result short of that number and again at that number. Simultaneous clear and completion is produced by raising the clear pulse in the same cycle as the final strobe.

// File: rtl/cmp_monitor_pkg.sv
package cmp_monitor_pkg;
    localparam int NUM_UNITS = 2;
    localparam int CHAN_W    = 4;
    localparam int DATA_W    = 12;
    localparam int MCNT_W    = 4;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_t;
endpackage

// File: rtl/cmp_test.sv
module cmp_test #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] thresh,
    input  logic              fmt_signed,
    input  logic              cond_ge,
    output logic              pass
);
    logic below;

    always_comb begin
        if (fmt_signed) below = $signed(data) < $signed(thresh);
        else            below = data < thresh;
        pass = cond_ge ? !below : below;
    end
endmodule

// File: rtl/cmp_unit.sv
module cmp_unit
    import cmp_monitor_pkg::*;
#(
    parameter int CHAN_W = 4,
    parameter int DATA_W = 12,
    parameter int MCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fmt_signed,
    input  logic              en,
    input  logic              cond_ge,
    input  logic [CHAN_W-1:0] sel,
    input  logic [MCNT_W-1:0] mcnt,
    input  logic [DATA_W-1:0] thresh,
    input  logic              clr,
    output logic              flag
);
    run_state_t        state, state_nx;
    logic [MCNT_W-1:0] run_cnt, run_cnt_nx;
    logic              pass, seen, done, miss;

    cmp_test #(.DATA_W(DATA_W)) u_test (
        .data      (wr_data),
        .thresh    (thresh),
        .fmt_signed(fmt_signed),
        .cond_ge   (cond_ge),
        .pass      (pass)
    );

    assign seen = wr_valid && en && (wr_chan == sel);
    assign done = seen && pass && (run_cnt == mcnt);
    assign miss = seen && !pass;

    always_comb begin
        state_nx   = state;
        run_cnt_nx = run_cnt;
        unique case (state)
            ST_IDLE: begin
                if (seen && pass && !done) begin
                    state_nx   = ST_COUNT;
                    run_cnt_nx = run_cnt + 1'b1;
                end else begin
                    run_cnt_nx = '0;
                end
            end
            ST_COUNT: begin
                if (!en || miss || done) begin
                    state_nx   = ST_IDLE;
                    run_cnt_nx = '0;
                end else if (seen && pass) begin
                    run_cnt_nx = run_cnt + 1'b1;
                end
            end
            default: begin
                state_nx   = ST_IDLE;
                run_cnt_nx = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            run_cnt <= '0;
        end else begin
            state   <= state_nx;
            run_cnt <= run_cnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    flag <= 1'b0;
        else if (done) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/cmp_monitor.sv
module cmp_monitor
    import cmp_monitor_pkg::*;
#(
    parameter int NUM_UNITS = cmp_monitor_pkg::NUM_UNITS,
    parameter int CHAN_W    = cmp_monitor_pkg::CHAN_W,
    parameter int DATA_W    = cmp_monitor_pkg::DATA_W,
    parameter int MCNT_W    = cmp_monitor_pkg::MCNT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_valid,
    input  logic [CHAN_W-1:0]           wr_chan,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        fmt_signed,
    input  logic [NUM_UNITS-1:0]        cfg_en,
    input  logic [NUM_UNITS-1:0]        cfg_irq_en,
    input  logic [NUM_UNITS-1:0]        cfg_cond,
    input  logic [NUM_UNITS*CHAN_W-1:0] cfg_chan,
    input  logic [NUM_UNITS*MCNT_W-1:0] cfg_mcnt,
    input  logic [NUM_UNITS*DATA_W-1:0] cfg_thresh,
    input  logic [NUM_UNITS-1:0]        flag_clr,
    output logic [NUM_UNITS-1:0]        flag,
    output logic                        irq
);
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        cmp_unit #(
            .CHAN_W(CHAN_W),
            .DATA_W(DATA_W),
            .MCNT_W(MCNT_W)
        ) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_valid  (wr_valid),
            .wr_chan   (wr_chan),
            .wr_data   (wr_data),
            .fmt_signed(fmt_signed),
            .en        (cfg_en[u]),
            .cond_ge   (cfg_cond[u]),
            .sel       (cfg_chan[u*CHAN_W +: CHAN_W]),
            .mcnt      (cfg_mcnt[u*MCNT_W +: MCNT_W]),
            .thresh    (cfg_thresh[u*DATA_W +: DATA_W]),
            .clr       (flag_clr[u]),
            .flag      (flag[u])
        );
    end

    assign irq = |(flag & cfg_irq_en);
endmodule

// File: rtl/cmp_monitor_chk.sv
module cmp_monitor_chk #(
    parameter int NUM_UNITS = 2,
    parameter int CHAN_W    = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_valid,
    input logic [CHAN_W-1:0]           wr_chan,
    input logic [NUM_UNITS-1:0]        cfg_en,
    input logic [NUM_UNITS-1:0]        cfg_irq_en,
    input logic [NUM_UNITS*CHAN_W-1:0] cfg_chan,
    input logic [NUM_UNITS-1:0]        flag_clr,
    input logic [NUM_UNITS-1:0]        flag,
    input logic                        irq
);
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[u]) |-> $past(cfg_en[u])); // R10
        AST_RISE_NEEDS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[u]) |-> $past(wr_valid && (wr_chan == cfg_chan[u*CHAN_W +: CHAN_W]))); // R1
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[u] && !flag_clr[u]) |=> flag[u]); // R8
        AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[u] && flag_clr[u] && !wr_valid) |=> !flag[u]); // R8
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & cfg_irq_en) == '0) |-> !irq); // R9
    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & cfg_irq_en) != '0) |-> irq); // R9
endmodule

bind cmp_monitor cmp_monitor_chk #(
    .NUM_UNITS(NUM_UNITS),
    .CHAN_W   (CHAN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_chan   (wr_chan),
    .cfg_en    (cfg_en),
    .cfg_irq_en(cfg_irq_en),
    .cfg_chan  (cfg_chan),
    .flag_clr  (flag_clr),
    .flag      (flag),
    .irq       (irq)
);

// File: tb/tb_cmp_monitor.sv
module tb_cmp_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_chan = '0;
    logic [11:0] wr_data = '0;
    logic        fmt_signed = 1'b0;
    logic [1:0]  cfg_en = '0;
    logic [1:0]  cfg_irq_en = '0;
    logic [1:0]  cfg_cond = '0;
    logic [7:0]  cfg_chan = '0;
    logic [7:0]  cfg_mcnt = '0;
    logic [23:0] cfg_thresh = '0;
    logic [1:0]  flag_clr = '0;
    logic [1:0]  flag;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    cmp_monitor dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
        .wr_data(wr_data), .fmt_signed(fmt_signed), .cfg_en(cfg_en),
        .cfg_irq_en(cfg_irq_en), .cfg_cond(cfg_cond), .cfg_chan(cfg_chan),
        .cfg_mcnt(cfg_mcnt), .cfg_thresh(cfg_thresh), .flag_clr(flag_clr),
        .flag(flag), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setup(input int u, input bit cond, input logic [3:0] ch,
                         input logic [3:0] mc, input logic [11:0] thr);
        cfg_cond[u]           = cond;
        cfg_chan[u*4 +: 4]    = ch;
        cfg_mcnt[u*4 +: 4]    = mc;
        cfg_thresh[u*12 +: 12] = thr;
        cfg_en[u]             = 1'b1;
    endtask

    // one-cycle strobe; flag updated when this returns
    task automatic send(input logic [3:0] ch, input logic [11:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_chan = ch; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // disable both units, clear both flags
    task automatic wipe();
        @(negedge clk);
        cfg_en = '0; flag_clr = 2'b11; cfg_irq_en = '0; fmt_signed = 1'b0;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic t_reset();
        check("R12 flags after reset", flag, 0);
        check("R12 irq after reset", irq, 0);
    endtask

    task automatic t_run_length();
        wipe();
        setup(0, 1'b1, 4'd3, 4'd2, 12'h800);
        send(4'd3, 12'h900);
        send(4'd3, 12'h900);
        check("R4 flag before count+1", flag[0], 0);
        send(4'd3, 12'h900);
        check("R4 flag at count+1", flag[0], 1);
        @(negedge clk); flag_clr[0] = 1'b1;
        @(negedge clk); flag_clr[0] = 1'b0;
        check("R8 flag cleared by pulse", flag[0], 0);
        send(4'd3, 12'h900);
        send(4'd3, 12'h900);
        check("R6 run restarts after flag", flag[0], 0);
        send(4'd3, 12'h900);
        check("R6 second run completes", flag[0], 1);
    endtask

    task automatic t_miss();
        wipe();
        setup(0, 1'b1, 4'd3, 4'd2, 12'h800);
        send(4'd3, 12'h900);
        send(4'd3, 12'h900);
        send(4'd3, 12'h100);
        send(4'd3, 12'h900);
        send(4'd3, 12'h900);
        check("R5 mismatch restarts run", flag[0], 0);
        send(4'd3, 12'h900);
        check("R5 full run after mismatch", flag[0], 1);
    endtask

    task automatic t_conditions();
        wipe();
        setup(0, 1'b0, 4'd0, 4'd0, 12'h100);
        send(4'd0, 12'h100);
        check("R2 equal is not below", flag[0], 0);
        send(4'd0, 12'h0FF);
        check("R2 below threshold matches", flag[0], 1);
        wipe();
        setup(0, 1'b1, 4'd0, 4'd0, 12'h100);
        send(4'd0, 12'h0FF);
        check("R3 below does not match ge", flag[0], 0);
        send(4'd0, 12'h100);
        check("R3 equal matches ge", flag[0], 1);
    endtask

    task automatic t_signed();
        wipe();
        setup(0, 1'b0, 4'd1, 4'd0, 12'h000);
        send(4'd1, 12'hFFF);
        check("R7 unsigned 0xFFF not below 0", flag[0], 0);
        fmt_signed = 1'b1;
        send(4'd1, 12'hFFF);
        check("R7 signed -1 below 0", flag[0], 1);
        wipe();
        fmt_signed = 1'b1;
        setup(0, 1'b1, 4'd1, 4'd0, 12'h800);
        send(4'd1, 12'h7FF);
        check("R7 signed max ge min threshold", flag[0], 1);
    endtask

    task automatic t_channel();
        wipe();
        setup(0, 1'b1, 4'd12, 4'd2, 12'h000);
        send(4'd12, 12'h010);
        send(4'd12, 12'h010);
        send(4'd13, 12'h010);
        send(4'd5, 12'h010);
        check("R1 other channels do not complete", flag[0], 0);
        send(4'd12, 12'h010);
        check("R1 run kept across other channels", flag[0], 1);
        wipe();
        setup(0, 1'b0, 4'd13, 4'd1, 12'h100);
        send(4'd13, 12'h010);
        send(4'd2, 12'hFFF);
        send(4'd13, 12'h010);
        check("R1 foreign mismatch ignored", flag[0], 1);
    endtask

    task automatic t_irq();
        wipe();
        setup(0, 1'b1, 4'd4, 4'd0, 12'h000);
        send(4'd4, 12'h001);
        check("R9 irq masked", irq, 0);
        @(negedge clk); cfg_irq_en = 2'b01; #1;
        check("R9 irq with enable", irq, 1);
        @(negedge clk); cfg_irq_en = 2'b10; #1;
        check("R9 other unit enable only", irq, 0);
    endtask

    task automatic t_disable();
        wipe();
        setup(0, 1'b1, 4'd6, 4'd1, 12'h000);
        send(4'd6, 12'h001);
        @(negedge clk); cfg_en[0] = 1'b0;
        @(negedge clk); cfg_en[0] = 1'b1;
        send(4'd6, 12'h001);
        check("R10 disable restarts run", flag[0], 0);
        send(4'd6, 12'h001);
        check("R10 run completes after enable", flag[0], 1);
        @(negedge clk); cfg_en[0] = 1'b0;
        @(negedge clk);
        check("R10 disable keeps flag", flag[0], 1);
        wipe();
        cfg_cond[0] = 1'b1; cfg_chan[3:0] = 4'd6; cfg_mcnt[3:0] = 4'd0;
        send(4'd6, 12'h001);
        check("R10 disabled unit ignores results", flag[0], 0);
    endtask

    task automatic t_clr_race();
        wipe();
        setup(0, 1'b1, 4'd7, 4'd0, 12'h000);
        send(4'd7, 12'h001);
        @(negedge clk);
        wr_valid = 1'b1; wr_chan = 4'd7; wr_data = 12'h001; flag_clr[0] = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; flag_clr[0] = 1'b0;
        check("R8 completion beats clear", flag[0], 1);
    endtask

    task automatic t_indep();
        wipe();
        setup(0, 1'b1, 4'd1, 4'd0, 12'h000);
        setup(1, 1'b1, 4'd2, 4'd1, 12'h000);
        send(4'd2, 12'h005);
        check("R11 unit1 partial run", flag, 0);
        send(4'd1, 12'h005);
        check("R11 unit0 alone", flag, 1);
        send(4'd2, 12'h005);
        check("R11 unit1 completes", flag, 3);
        wipe();
        setup(0, 1'b0, 4'd9, 4'd0, 12'h100);
        setup(1, 1'b1, 4'd9, 4'd0, 12'h100);
        send(4'd9, 12'h050);
        check("R11 same result, different conditions", flag, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run_length();
        t_miss();
        t_conditions();
        t_signed();
        t_channel();
        t_irq();
        t_disable();
        t_clr_race();
        t_indep();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule